// File: doc/BRIEF.md
# Polled Asynchronous Serial Port

A byte-wide register interface in front of one asynchronous serial transmitter and one receiver. Both run from a baud generator derived from the bus clock. Software first sets a global enable and then enables the transmitter and the receiver on their own. It polls a transmit-empty flag before it writes a byte and a receive-full flag before it reads one. On the line, every frame is one start bit (low), eight data bits sent least significant bit first, and one stop bit (high), with no inversion and no parity.

Register accesses are synchronous and take one cycle each. A write is taken on the clock edge at which the write strobe is high. A read returns the addressed register on `rd_data` after the edge at which the read strobe is high. The address map is: 0 control A, 1 control B, 2 status (read only), 3 data, 4 baud. The bit time is the bus clock period × 64 × prescale × 2^rate. The receiver samples its input at 16 times the bit rate, and so does the transmitter's bit timer.

The transmitter state machine has four states: TX_IDLE, TX_START, TX_DATA and TX_STOP. It goes from TX_IDLE to TX_START on a baud tick when the holding register is full. TX_START goes to TX_DATA after 16 ticks. TX_DATA goes to TX_STOP after its eighth bit. TX_STOP goes back to TX_START if a byte is waiting, and to TX_IDLE otherwise. The receiver state machine has the states RX_IDLE, RX_START, RX_DATA and RX_STOP. It goes from RX_IDLE to RX_START on a tick that sees a low line. RX_START goes to RX_DATA if the line is still low at mid start bit, and back to RX_IDLE if it is not. RX_DATA goes to RX_STOP after eight samples. RX_STOP always returns to RX_IDLE, and it delivers the byte only if the stop sample is high.

Top module: `sci_port`

## Requirements
- R1: After reset, control A, control B and baud read 0x00, status reads 0x80, and `txd` is high.
- R2: Bit 6 of control A is the global enable. While it is 0, `txd` stays high, data writes are ignored, incoming frames are ignored, and status reads 0x80.
- R3: Bit 3 of control B enables the transmitter. While it is 0 (or the global enable is 0), a write to the data register is ignored, status bit 7 stays 1, and no frame is sent.
- R4: Bit 2 of control B enables the receiver. While it is 0, incoming frames do not set receive-full.
- R5: Status bit 7 is transmit-empty. An accepted data write clears it from the next cycle on. It sets again when the byte moves into the shifter, which happens within one bit time while the line is idle.
- R6: A transmitted frame is a start bit (0), data bits 0 to 7, and a stop bit (1). Each bit lasts exactly L = 64 × P × 2^N bus cycles. A byte written while a frame is in flight starts on the cycle directly after that frame's stop bit.
- R7: Baud register bits [5:4] select the prescale P: 0→1, 1→3, 2→4, 3→13. Bits [2:0] give N. The register reads back as written.
- R8: A received frame with a high stop bit sets status bit 5 (receive-full). A data read returns the byte and clears bit 5 and bit 3.
- R9: If a frame completes while receive-full is set, status bit 3 (overrun) sets and the data register keeps the older byte.
- R10: A frame whose stop sample is low is discarded: receive-full is not set, and the next good frame is received normally.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous reset, active high |
| addr | input | 3 | Register address |
| wr | input | 1 | Write strobe |
| rd | input | 1 | Read strobe |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data, valid after the read edge |
| rxd | input | 1 | Serial input, idle high |
| txd | output | 1 | Serial output, idle high |

## Verification
A transmitter stuck in the wrong state, or with a bit counter off by one, shows on `txd` within a single bit time. The reference waveform is anchored on the falling start edge and compared on every cycle, so a wrong bit value or a bit cut short by even one cycle shows up as a mismatch. A wrong holding flag shows on the next status read: a cleared flag that never sets again leaves transmit-empty at 0, and a flag that sets with nothing pending sends a frame that no write asked for. A receiver that samples at the wrong point, or keeps the wrong flag state, shows up when the frame that follows is read back or polled: wrong data, a missing receive-full, or an overrun that is missing or left standing.

// File: rtl/sci_pkg.sv
package sci_pkg;

    localparam logic [2:0] A_CTRLA = 3'd0;
    localparam logic [2:0] A_CTRLB = 3'd1;
    localparam logic [2:0] A_STAT  = 3'd2;
    localparam logic [2:0] A_DATA  = 3'd3;
    localparam logic [2:0] A_BAUD  = 3'd4;

    localparam int EN_BIT   = 6;
    localparam int TE_BIT   = 3;
    localparam int RE_BIT   = 2;
    localparam int TEMP_BIT = 7;
    localparam int RFUL_BIT = 5;
    localparam int OVR_BIT  = 3;

    typedef enum logic [1:0] {TX_IDLE, TX_START, TX_DATA, TX_STOP} tx_state_t;
    typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;

    function automatic logic [3:0] prescale_of(input logic [1:0] sel);
        case (sel)
            2'd0:    prescale_of = 4'd1;
            2'd1:    prescale_of = 4'd3;
            2'd2:    prescale_of = 4'd4;
            default: prescale_of = 4'd13;
        endcase
    endfunction

endpackage

// File: rtl/sci_baud.sv
module sci_baud #(
    parameter int OVS      = 16,
    parameter int BASE_DIV = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic [1:0] psel,
    input  logic [2:0] rsel,
    output logic       tick
);
    import sci_pkg::*;

    localparam int STEP = BASE_DIV / OVS;
    localparam int MAXP = STEP * 13 * 128;
    localparam int CW   = $clog2(MAXP + 1);

    logic [CW-1:0] period;
    logic [CW-1:0] cnt;

    always_comb begin
        period = CW'(STEP) * (CW'(prescale_of(psel)) << rsel);
        tick   = en && (cnt == period - CW'(1));
    end

    always_ff @(posedge clk) begin
        if (rst || !en)
            cnt <= '0;
        else if (tick)
            cnt <= '0;
        else
            cnt <= cnt + CW'(1);
    end

endmodule

// File: rtl/sci_tx.sv
module sci_tx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       hold_full,
    input  logic [7:0] hold_byte,
    output logic       load,
    output logic       txd
);
    import sci_pkg::*;

    localparam int SW = $clog2(OVS);

    tx_state_t      state, nxt;
    logic [SW-1:0]  sub;
    logic [2:0]     bitn;
    logic [7:0]     sh;
    logic           last_sub;

    assign last_sub = tick && (sub == SW'(OVS - 1));

    always_comb begin
        nxt  = state;
        load = 1'b0;
        unique case (state)
            TX_IDLE:  if (tick && hold_full) begin
                          nxt  = TX_START;
                          load = 1'b1;
                      end
            TX_START: if (last_sub) nxt = TX_DATA;
            TX_DATA:  if (last_sub && bitn == 3'd7) nxt = TX_STOP;
            TX_STOP:  if (last_sub) begin
                          if (hold_full) begin
                              nxt  = TX_START;
                              load = 1'b1;
                          end else begin
                              nxt = TX_IDLE;
                          end
                      end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state <= TX_IDLE;
            sub   <= '0;
            bitn  <= '0;
            sh    <= 8'hFF;
        end else begin
            state <= nxt;
            if (load) begin
                sh   <= hold_byte;
                sub  <= '0;
                bitn <= '0;
            end else if (tick) begin
                sub <= last_sub ? '0 : sub + SW'(1);
                if (state == TX_DATA && last_sub) begin
                    sh   <= {1'b1, sh[7:1]};
                    bitn <= bitn + 3'd1;
                end
            end
        end
    end

    always_comb begin
        unique case (state)
            TX_START: txd = 1'b0;
            TX_DATA:  txd = sh[0];
            default:  txd = 1'b1;
        endcase
    end

endmodule

// File: rtl/sci_rx.sv
module sci_rx #(
    parameter int OVS = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  logic       tick,
    input  logic       rxd,
    output logic       done,
    output logic [7:0] rx_byte
);
    import sci_pkg::*;

    localparam int SW  = $clog2(OVS);
    localparam int MID = OVS / 2;

    rx_state_t      state, nxt;
    logic [SW-1:0]  sub;
    logic [2:0]     bitn;
    logic [7:0]     sh;
    logic           s1, s2;
    logic           last_sub;
    logic           mid_start;

    assign last_sub  = tick && (sub == SW'(OVS - 1));
    assign mid_start = tick && (sub == SW'(MID - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= 1'b1;
            s2 <= 1'b1;
        end else begin
            s1 <= rxd;
            s2 <= s1;
        end
    end

    always_comb begin
        nxt = state;
        unique case (state)
            RX_IDLE:  if (tick && !s2) nxt = RX_START;
            RX_START: if (mid_start) nxt = s2 ? RX_IDLE : RX_DATA;
            RX_DATA:  if (last_sub && bitn == 3'd7) nxt = RX_STOP;
            RX_STOP:  if (last_sub) nxt = RX_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            state   <= RX_IDLE;
            sub     <= '0;
            bitn    <= '0;
            sh      <= '0;
            done    <= 1'b0;
            rx_byte <= '0;
        end else begin
            state <= nxt;
            done  <= 1'b0;
            if (tick) begin
                if (state == RX_IDLE || (state == RX_START && mid_start)) begin
                    sub  <= '0;
                    bitn <= '0;
                end else begin
                    sub <= last_sub ? '0 : sub + SW'(1);
                end
            end
            if (state == RX_DATA && last_sub) begin
                sh   <= {s2, sh[7:1]};
                bitn <= bitn + 3'd1;
            end
            if (state == RX_STOP && last_sub && s2) begin
                done    <= 1'b1;
                rx_byte <= sh;
            end
        end
    end

endmodule

// File: rtl/sci_port.sv
module sci_port #(
    parameter int OVS      = 16,
    parameter int BASE_DIV = 64
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [2:0] addr,
    input  logic       wr,
    input  logic       rd,
    input  logic [7:0] wr_data,
    output logic [7:0] rd_data,
    input  logic       rxd,
    output logic       txd
);
    import sci_pkg::*;

    logic [7:0] ctrl_a, ctrl_b, baud;
    logic [7:0] hold, rx_data;
    logic       hold_full, rdrf, ovr;
    logic       glob_en, tx_en, rx_en;
    logic       tick, tx_load, rx_done;
    logic [7:0] rx_byte;
    logic       data_wr, data_rd, tx_empty;
    logic [7:0] status;

    assign glob_en  = ctrl_a[EN_BIT];
    assign tx_en    = glob_en && ctrl_b[TE_BIT];
    assign rx_en    = glob_en && ctrl_b[RE_BIT];
    assign data_wr  = wr && (addr == A_DATA) && tx_en;
    assign data_rd  = rd && (addr == A_DATA);
    assign tx_empty = !hold_full;

    always_comb begin
        status           = 8'h00;
        status[TEMP_BIT] = tx_empty;
        status[RFUL_BIT] = rdrf;
        status[OVR_BIT]  = ovr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_a <= '0;
            ctrl_b <= '0;
            baud   <= '0;
        end else if (wr) begin
            if (addr == A_CTRLA) ctrl_a <= wr_data;
            if (addr == A_CTRLB) ctrl_b <= wr_data;
            if (addr == A_BAUD)  baud   <= wr_data;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !tx_en) begin
            hold      <= '0;
            hold_full <= 1'b0;
        end else if (data_wr) begin
            hold      <= wr_data;
            hold_full <= 1'b1;
        end else if (tx_load) begin
            hold_full <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !rx_en) begin
            rx_data <= '0;
            rdrf    <= 1'b0;
            ovr     <= 1'b0;
        end else begin
            if (rx_done && !rdrf) begin
                rx_data <= rx_byte;
                rdrf    <= 1'b1;
            end else if (data_rd) begin
                rdrf <= 1'b0;
            end
            if (rx_done && rdrf)
                ovr <= 1'b1;
            else if (data_rd)
                ovr <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            rd_data <= '0;
        end else if (rd) begin
            case (addr)
                A_CTRLA: rd_data <= ctrl_a;
                A_CTRLB: rd_data <= ctrl_b;
                A_STAT:  rd_data <= status;
                A_DATA:  rd_data <= rx_data;
                A_BAUD:  rd_data <= baud;
                default: rd_data <= 8'h00;
            endcase
        end
    end

    sci_baud #(.OVS(OVS), .BASE_DIV(BASE_DIV)) u_baud (
        .clk(clk), .rst(rst), .en(glob_en),
        .psel(baud[5:4]), .rsel(baud[2:0]), .tick(tick)
    );

    sci_tx #(.OVS(OVS)) u_tx (
        .clk(clk), .rst(rst), .en(tx_en), .tick(tick),
        .hold_full(hold_full), .hold_byte(hold),
        .load(tx_load), .txd(txd)
    );

    sci_rx #(.OVS(OVS)) u_rx (
        .clk(clk), .rst(rst), .en(rx_en), .tick(tick),
        .rxd(rxd), .done(rx_done), .rx_byte(rx_byte)
    );

endmodule

// File: rtl/sci_port_chk.sv
module sci_port_chk (
    input logic       clk,
    input logic       rst,
    input logic       en,
    input logic       te,
    input logic       re,
    input logic       wr,
    input logic       rd,
    input logic [2:0] addr,
    input logic       txd,
    input logic       tx_empty,
    input logic       rdrf,
    input logic       ovr,
    input logic       rx_done
);
    import sci_pkg::*;

    p_line_high_r2: assert property (@(posedge clk) disable iff (rst)
        (!en && $past(!en)) |-> txd);

    p_empty_clear_r5: assert property (@(posedge clk) disable iff (rst)
        (wr && addr == A_DATA && te) |=> !tx_empty);

    p_quiet_rx_r4: assert property (@(posedge clk) disable iff (rst)
        (!re && $past(!re)) |-> !rx_done);

    p_rdrf_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (rd && addr == A_DATA && rdrf && re) |=> !rdrf);

    p_overrun_r9: assert property (@(posedge clk) disable iff (rst)
        (rx_done && rdrf && re) |=> ovr);

endmodule

bind sci_port sci_port_chk u_chk (
    .clk(clk), .rst(rst), .en(glob_en), .te(tx_en), .re(rx_en),
    .wr(wr), .rd(rd), .addr(addr), .txd(txd), .tx_empty(tx_empty),
    .rdrf(rdrf), .ovr(ovr), .rx_done(rx_done)
);

// File: tb/sim_sci_port.sv
`timescale 1ns/1ps
module sim_sci_port;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [2:0] addr = 3'd0;
    logic       wr = 1'b0;
    logic       rd = 1'b0;
    logic [7:0] wr_data = 8'h00;
    logic [7:0] rd_data;
    logic       rxd = 1'b1;
    logic       txd;

    int checks = 0;
    int fails  = 0;
    int bitlen = 64;
    int frames = 0;
    int cyc    = 0;
    int last_end = 0;
    int last_gap = 0;
    logic [7:0] expq[$];
    bit   busy = 1'b0;
    bit   bad  = 1'b0;
    int   pos  = 0;
    logic [7:0] cur = 8'h00;
    logic [7:0] v;
    bit   done_flag = 1'b0;

    always #2.5 clk = ~clk;

    sci_port u0 (
        .clk(clk), .rst(rst), .addr(addr), .wr(wr), .rd(rd),
        .wr_data(wr_data), .rd_data(rd_data), .rxd(rxd), .txd(txd)
    );

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    function automatic logic frame_bit(input logic [7:0] b, input int idx);
        if (idx == 0) return 1'b0;
        if (idx == 9) return 1'b1;
        return b[idx-1];
    endfunction

    // Reference model of the line: anchored on the start edge, compared every cycle
    always @(negedge clk) begin
        cyc++;
        if (!rst) begin
            if (!busy && txd == 1'b0) begin
                if (expq.size() == 0) begin
                    chk(1'b0, "R2/R3 unexpected frame on txd", 0, 1);
                end else begin
                    cur = expq.pop_front();
                    busy = 1'b1;
                    pos = 0;
                    bad = 1'b0;
                    last_gap = cyc - last_end;
                end
            end
            if (busy) begin
                if (txd !== frame_bit(cur, pos / bitlen)) bad = 1'b1;
                pos++;
                if (pos == 10 * bitlen) begin
                    busy = 1'b0;
                    frames++;
                    last_end = cyc;
                    chk(!bad, "R6 frame waveform", 0, int'(cur));
                end
            end
        end
    end

    task automatic wreg(input logic [2:0] a, input logic [7:0] d);
        addr = a; wr_data = d; wr = 1'b1;
        @(negedge clk);
        wr = 1'b0;
    endtask

    task automatic rreg(input logic [2:0] a, output logic [7:0] d);
        addr = a; rd = 1'b1;
        @(negedge clk);
        rd = 1'b0;
        d = rd_data;
    endtask

    task automatic expect_reg(input logic [2:0] a, input logic [7:0] e, input string tag);
        logic [7:0] got;
        rreg(a, got);
        chk(got === e, tag, int'(got), int'(e));
    endtask

    task automatic send_byte(input logic [7:0] b);
        expq.push_back(b);
        wreg(3'd3, b);
    endtask

    task automatic rx_frame(input logic [7:0] b, input logic stopb);
        rxd = 1'b0;
        repeat (bitlen) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rxd = b[i];
            repeat (bitlen) @(negedge clk);
        end
        rxd = stopb;
        repeat (bitlen) @(negedge clk);
        rxd = 1'b1;
        repeat (bitlen) @(negedge clk);
    endtask

    task automatic wait_frames(input int n);
        while (frames < n) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done_flag) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        int polls;
        int f0;
        repeat (5) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        chk(txd === 1'b1, "R1 txd idle", int'(txd), 1);
        expect_reg(3'd0, 8'h00, "R1 control A");
        expect_reg(3'd1, 8'h00, "R1 control B");
        expect_reg(3'd2, 8'h80, "R1 status");
        expect_reg(3'd4, 8'h00, "R1 baud");

        // enable, default baud: L = 64
        bitlen = 64;
        wreg(3'd4, 8'h00);
        wreg(3'd0, 8'h40);
        wreg(3'd1, 8'h0C);

        // R5 empty flag clears on write, sets within one bit time
        send_byte(8'hA5);
        rreg(3'd2, v);
        chk(v[7] === 1'b0, "R5 empty cleared after write", int'(v), 8'h00);
        polls = 0;
        do begin rreg(3'd2, v); polls++; end while (!v[7] && polls < 200);
        chk(v[7] === 1'b1 && polls <= bitlen, "R5 empty set after load", polls, bitlen);

        // R6 back-to-back frame is contiguous
        send_byte(8'h3C);
        wait_frames(2);
        chk(last_gap == 1, "R6 back-to-back gap", last_gap, 1);

        // R8 receive
        rx_frame(8'h96, 1'b1);
        expect_reg(3'd2, 8'hA0, "R8 receive-full set");
        expect_reg(3'd3, 8'h96, "R8 received byte");
        expect_reg(3'd2, 8'h80, "R8 receive-full cleared");

        // R9 overrun keeps the older byte
        rx_frame(8'h11, 1'b1);
        rx_frame(8'h22, 1'b1);
        expect_reg(3'd2, 8'hA8, "R9 overrun set");
        expect_reg(3'd3, 8'h11, "R9 older byte kept");
        expect_reg(3'd2, 8'h80, "R9 overrun cleared by read");

        // R10 bad stop bit discarded, then recovery
        rx_frame(8'h77, 1'b0);
        expect_reg(3'd2, 8'h80, "R10 bad frame discarded");
        rx_frame(8'h5A, 1'b1);
        expect_reg(3'd3, 8'h5A, "R10 next frame received");

        // R7 prescale 13, rate 1: L = 64*13*2
        wreg(3'd4, 8'h31);
        bitlen = 64 * 13 * 2;
        expect_reg(3'd4, 8'h31, "R7 baud readback");
        send_byte(8'hC3);
        wait_frames(3);
        rx_frame(8'hE1, 1'b1);
        expect_reg(3'd3, 8'hE1, "R7 receive at slow rate");

        // R7 prescale 4, rate 0: L = 256
        wreg(3'd4, 8'h20);
        bitlen = 256;
        send_byte(8'h0F);
        wait_frames(4);
        chk(frames == 4, "R7 frame at prescale 4", frames, 4);

        // R3 transmitter disabled
        bitlen = 64;
        wreg(3'd4, 8'h00);
        wreg(3'd1, 8'h04);
        wreg(3'd3, 8'h55);
        expect_reg(3'd2, 8'h80, "R3 write ignored, empty stays");
        f0 = frames;
        repeat (20 * bitlen) @(negedge clk);
        chk(frames == f0 && txd === 1'b1, "R3 no frame sent", frames, f0);

        // R4 receiver disabled
        wreg(3'd1, 8'h08);
        rx_frame(8'h44, 1'b1);
        expect_reg(3'd2, 8'h80, "R4 frame ignored");

        // R2 global disable
        wreg(3'd1, 8'h0C);
        wreg(3'd0, 8'h00);
        wreg(3'd3, 8'h66);
        expect_reg(3'd2, 8'h80, "R2 status while disabled");
        rx_frame(8'h12, 1'b1);
        chk(txd === 1'b1, "R2 line high", int'(txd), 1);
        wreg(3'd0, 8'h40);
        repeat (20 * bitlen) @(negedge clk);
        expect_reg(3'd2, 8'h80, "R2 nothing pending after re-enable");
        chk(frames == f0, "R2 no frame from ignored write", frames, f0);

        done_flag = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule